// File: doc/BRIEF.md
# Encoded-Audio Burst Subframe Formatter

This block carries a compressed audio bitstream over a two-channel digital audio link. It does not send PCM samples. It sends the stream as data bursts built from 16-bit words, one word in each subframe. Each burst opens with four header words: two fixed sync words, a word naming the stream and the data type, and a word giving the payload length. The payload words follow. Every remaining subframe up to the end of the burst repetition period is filled with zero.

The link side asks for one subframe at a time with a single-cycle request. The subframes alternate between channel A and channel B. For each request the block returns a registered 32-bit time-slot image. The image holds the data word, the validity, user and channel-status bits and an even-parity bit. A later stage adds the line coding and the preamble patterns of slots 0 to 3. Payload words come from a show-ahead source that the block pops once per payload subframe.

A burst request carries the data type, the stream number, the payload length in words and the period in subframes. The period must be even and at least four more than the length. A request that arrives while a burst is still in its period is held until that period ends. A burst always begins on channel A.

Top module: `nonpcm_burst_fmt`

## Requirements
- R1: The first two subframes of a burst carry the words 0xF872 and then 0x4E1F, and the first of them is always a channel A subframe.
- R2: The third burst subframe carries the type word: data type in bits 4:0, stream number in bits 15:13, and all other bits zero.
- R3: The fourth burst subframe carries the payload length in bits, which is the word count times 16.
- R4: Payload word k goes out in burst subframe 4+k, in the order the source presents the words. Each one is taken with a single `pay_pop` pulse in the cycle of its request.
- R5: After the payload, every subframe until `burst_period` subframes have passed since the burst start carries the word 0. When no burst is running, every subframe carries the word 0.
- R6: In the image, bit i is time slot i. The data word sits in slots 12 to 27 with its LSB in slot 12, and slots 0 to 11 are zero.
- R7: Slot 28 (validity) is always 1. Slot 29 carries `sf_user` and slot 30 carries `sf_cs`, both sampled with the request.
- R8: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R9: The subframes alternate between channel A and channel B, starting with A after reset. `sf_chan_b` is 1 for a B image.
- R10: If the source has no word (`pay_avail` low) when a payload subframe is requested, that subframe carries 0, `sf_underrun` is 1 for that image, and no word is popped. The next payload subframe takes the word that was not sent.
- R11: A burst request made while a burst is still inside its period is held, and the new burst starts in the first subframe after the period ends. A request made when the next subframe is a B subframe waits one subframe.
- R12: While reset is active, `sf_img`, `sf_valid`, `sf_underrun` and `sf_chan_b` are 0 and no request is pending.
- R13: The image, the channel flag and the underrun flag are updated on the clock edge that samples `sf_req`. `sf_valid` is high only in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_req | input | 1 | Single-cycle request for the next subframe |
| sf_user | input | 1 | User data bit for the requested subframe |
| sf_cs | input | 1 | Channel-status bit for the requested subframe |
| burst_start | input | 1 | Single-cycle burst request; captures the four burst fields |
| burst_type | input | 5 | Data type placed in the type word |
| burst_stream | input | 3 | Stream number placed in the type word |
| burst_len | input | LEN_W | Payload length in 16-bit words |
| burst_period | input | PER_W | Burst repetition period in subframes |
| pay_word | input | 16 | Show-ahead payload word |
| pay_avail | input | 1 | `pay_word` is valid |
| pay_pop | output | 1 | Consumes `pay_word` in this cycle |
| sf_img | output | 32 | Time-slot image of the last requested subframe |
| sf_valid | output | 1 | `sf_img` was updated at the last edge |
| sf_chan_b | output | 1 | The image belongs to channel B |
| sf_underrun | output | 1 | The image's payload word was missing |

## Verification
The assertions check, on every cycle:
- the fixed slots of every image: slots 0 to 11 zero, validity 1 and even parity;
- one-cycle `sf_valid` timing;
- channel alternation;
- that the first sync word only goes out on channel A;
- that the position counter never reaches the period;
- that a pending request survives until it is used;
- that no word is popped during an underrun.

Only the bench scenarios can show the full word sequence of a burst against an independent model: the header contents, payload order, the number of stuffing subframes, the exact subframe at which a deferred burst begins, and how the payload slips after an underrun.

// File: rtl/afmt_pkg.sv
package afmt_pkg;

  localparam logic [15:0] SYNC_WORD_A    = 16'hF872;
  localparam logic [15:0] SYNC_WORD_B    = 16'h4E1F;
  localparam int          HEADER_WORDS   = 4;
  localparam int          DATA_LSB_SLOT  = 12;
  localparam int          FIRST_PAR_SLOT = 4;
  localparam int          VALID_SLOT     = 28;
  localparam int          USER_SLOT      = 29;
  localparam int          CSTAT_SLOT     = 30;
  localparam int          PARITY_SLOT    = 31;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_SYNC_A,
    WK_SYNC_B,
    WK_INFO,
    WK_LEN,
    WK_PAY,
    WK_STUFF
  } word_kind_e;

  // type word: stream number on top, data type at the bottom
  function automatic logic [15:0] type_word(input logic [4:0] dtype,
                                            input logic [2:0] stream);
    return {stream, 8'h00, dtype};
  endfunction

  // payload size in bits from a word count
  function automatic logic [15:0] length_bits(input logic [15:0] words);
    return {words[11:0], 4'h0};
  endfunction

  // full 32-slot image with even parity over slots 4..31
  function automatic logic [31:0] slot_image(input logic [15:0] word,
                                             input logic user_bit,
                                             input logic cs_bit);
    logic [31:0] s;
    s = '0;
    s[DATA_LSB_SLOT +: 16] = word;
    s[VALID_SLOT]          = 1'b1;
    s[USER_SLOT]           = user_bit;
    s[CSTAT_SLOT]          = cs_bit;
    s[PARITY_SLOT]         = ^s[PARITY_SLOT-1:FIRST_PAR_SLOT];
    return s;
  endfunction

endpackage

// File: rtl/afmt_burst_ctrl.sv
module afmt_burst_ctrl #(
  parameter int LEN_W = 12,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_req,
  input  logic             burst_start,
  input  logic [4:0]       req_type,
  input  logic [2:0]       req_stream,
  input  logic [LEN_W-1:0] req_len,
  input  logic [PER_W-1:0] req_period,
  output logic             eff_active,
  output logic [PER_W-1:0] eff_pos,
  output logic [4:0]       eff_type,
  output logic [2:0]       eff_stream,
  output logic [LEN_W-1:0] eff_len,
  output logic             chan_b
);

  logic             active_q;
  logic [PER_W-1:0] pos_q;
  logic [4:0]       cur_type;
  logic [2:0]       cur_stream;
  logic [LEN_W-1:0] cur_len;
  logic [PER_W-1:0] cur_period;

  logic             pend_q;
  logic [4:0]       pend_type;
  logic [2:0]       pend_stream;
  logic [LEN_W-1:0] pend_len;
  logic [PER_W-1:0] pend_period;

  logic             chan_q;
  logic             start_fire;
  logic [PER_W-1:0] eff_period;
  logic [PER_W:0]   next_pos;
  logic             period_last;

  // a held request fires only on an A subframe when no burst is running
  assign start_fire  = sf_req & pend_q & ~active_q & ~chan_q;
  assign eff_active  = active_q | start_fire;
  assign eff_pos     = start_fire ? '0 : pos_q;
  assign eff_type    = start_fire ? pend_type   : cur_type;
  assign eff_stream  = start_fire ? pend_stream : cur_stream;
  assign eff_len     = start_fire ? pend_len    : cur_len;
  assign eff_period  = start_fire ? pend_period : cur_period;
  assign next_pos    = {1'b0, eff_pos} + 1'b1;
  assign period_last = next_pos >= {1'b0, eff_period};
  assign chan_b      = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_type   <= '0;
      pend_stream <= '0;
      pend_len    <= '0;
      pend_period <= '0;
    end else if (burst_start) begin
      pend_q      <= 1'b1;
      pend_type   <= req_type;
      pend_stream <= req_stream;
      pend_len    <= req_len;
      pend_period <= req_period;
    end else if (start_fire) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      pos_q      <= '0;
      chan_q     <= 1'b0;
      cur_type   <= '0;
      cur_stream <= '0;
      cur_len    <= '0;
      cur_period <= '0;
    end else if (sf_req) begin
      chan_q <= ~chan_q;
      if (start_fire) begin
        cur_type   <= pend_type;
        cur_stream <= pend_stream;
        cur_len    <= pend_len;
        cur_period <= pend_period;
      end
      if (eff_active) begin
        if (period_last) begin
          active_q <= 1'b0;
          pos_q    <= '0;
        end else begin
          active_q <= 1'b1;
          pos_q    <= next_pos[PER_W-1:0];
        end
      end
    end
  end

  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (pos_q < cur_period));

  p_chan_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sf_req |=> (chan_q != $past(chan_q)));

  p_burst_from_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> chan_q);

  p_pend_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sf_req) |=> pend_q);

endmodule

// File: rtl/afmt_word_sel.sv
module afmt_word_sel
  import afmt_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_req,
  input  logic             chan_b,
  input  logic             eff_active,
  input  logic [PER_W-1:0] eff_pos,
  input  logic [4:0]       eff_type,
  input  logic [2:0]       eff_stream,
  input  logic [LEN_W-1:0] eff_len,
  input  logic [15:0]      pay_word,
  input  logic             pay_avail,
  output logic [15:0]      word_out,
  output logic             pay_pop,
  output logic             underrun
);

  localparam int CMP_W = ((PER_W > LEN_W) ? PER_W : LEN_W) + 1;

  word_kind_e       kind;
  logic [CMP_W-1:0] rel_pos;
  logic             in_payload;
  logic             need_word;

  assign rel_pos    = CMP_W'(eff_pos) - CMP_W'(HEADER_WORDS);
  assign in_payload = (eff_pos >= PER_W'(HEADER_WORDS)) && (rel_pos < CMP_W'(eff_len));

  always_comb begin
    kind = WK_IDLE;
    if (eff_active) begin
      if      (eff_pos == PER_W'(0)) kind = WK_SYNC_A;
      else if (eff_pos == PER_W'(1)) kind = WK_SYNC_B;
      else if (eff_pos == PER_W'(2)) kind = WK_INFO;
      else if (eff_pos == PER_W'(3)) kind = WK_LEN;
      else if (in_payload)           kind = WK_PAY;
      else                           kind = WK_STUFF;
    end
  end

  assign need_word = sf_req && (kind == WK_PAY);
  assign pay_pop   = need_word && pay_avail;
  assign underrun  = need_word && !pay_avail;

  always_comb begin
    case (kind)
      WK_SYNC_A: word_out = SYNC_WORD_A;
      WK_SYNC_B: word_out = SYNC_WORD_B;
      WK_INFO:   word_out = type_word(eff_type, eff_stream);
      WK_LEN:    word_out = length_bits(16'(eff_len));
      WK_PAY:    word_out = pay_avail ? pay_word : 16'h0000;
      default:   word_out = 16'h0000;
    endcase
  end

  p_sync_on_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_req && kind == WK_SYNC_A) |-> !chan_b);

  p_len_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_req && kind == WK_LEN) |-> (word_out[3:0] == 4'h0));

  p_no_pop_on_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !pay_pop);

endmodule

// File: rtl/afmt_sf_pack.sv
module afmt_sf_pack
  import afmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sf_req,
  input  logic [15:0] word_in,
  input  logic        user_in,
  input  logic        cs_in,
  input  logic        chan_b_in,
  input  logic        underrun_in,
  output logic [31:0] sf_img,
  output logic        sf_valid,
  output logic        sf_chan_b,
  output logic        sf_underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_img      <= '0;
      sf_valid    <= 1'b0;
      sf_chan_b   <= 1'b0;
      sf_underrun <= 1'b0;
    end else begin
      sf_valid <= sf_req;
      if (sf_req) begin
        sf_img      <= slot_image(word_in, user_in, cs_in);
        sf_chan_b   <= chan_b_in;
        sf_underrun <= underrun_in;
      end
    end
  end

  p_even_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> (^sf_img[31:4] == 1'b0));

  p_valid_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> sf_img[VALID_SLOT]);

  p_low_slots_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sf_valid |-> (sf_img[11:0] == 12'h000));

  p_valid_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sf_req |=> sf_valid);

  p_valid_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_req |=> !sf_valid);

endmodule

// File: rtl/nonpcm_burst_fmt.sv
module nonpcm_burst_fmt #(
  parameter int LEN_W = 12,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_req,
  input  logic             sf_user,
  input  logic             sf_cs,
  input  logic             burst_start,
  input  logic [4:0]       burst_type,
  input  logic [2:0]       burst_stream,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [PER_W-1:0] burst_period,
  input  logic [15:0]      pay_word,
  input  logic             pay_avail,
  output logic             pay_pop,
  output logic [31:0]      sf_img,
  output logic             sf_valid,
  output logic             sf_chan_b,
  output logic             sf_underrun
);

  logic             eff_active;
  logic [PER_W-1:0] eff_pos;
  logic [4:0]       eff_type;
  logic [2:0]       eff_stream;
  logic [LEN_W-1:0] eff_len;
  logic             chan_b;
  logic [15:0]      sel_word;
  logic             sel_underrun;

  afmt_burst_ctrl #(.LEN_W(LEN_W), .PER_W(PER_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sf_req      (sf_req),
    .burst_start (burst_start),
    .req_type    (burst_type),
    .req_stream  (burst_stream),
    .req_len     (burst_len),
    .req_period  (burst_period),
    .eff_active  (eff_active),
    .eff_pos     (eff_pos),
    .eff_type    (eff_type),
    .eff_stream  (eff_stream),
    .eff_len     (eff_len),
    .chan_b      (chan_b)
  );

  afmt_word_sel #(.LEN_W(LEN_W), .PER_W(PER_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf_req     (sf_req),
    .chan_b     (chan_b),
    .eff_active (eff_active),
    .eff_pos    (eff_pos),
    .eff_type   (eff_type),
    .eff_stream (eff_stream),
    .eff_len    (eff_len),
    .pay_word   (pay_word),
    .pay_avail  (pay_avail),
    .word_out   (sel_word),
    .pay_pop    (pay_pop),
    .underrun   (sel_underrun)
  );

  afmt_sf_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .sf_req      (sf_req),
    .word_in     (sel_word),
    .user_in     (sf_user),
    .cs_in       (sf_cs),
    .chan_b_in   (chan_b),
    .underrun_in (sel_underrun),
    .sf_img      (sf_img),
    .sf_valid    (sf_valid),
    .sf_chan_b   (sf_chan_b),
    .sf_underrun (sf_underrun)
  );

endmodule

// File: tb/nonpcm_burst_fmt_tb.sv
module nonpcm_burst_fmt_tb;

  typedef struct packed {
    logic [4:0]  dt;
    logic [2:0]  sn;
    logic [11:0] len;
    logic [15:0] rep;
  } vec_t;

  localparam vec_t VTAB [4] = '{
    vec_t'{5'd5,  3'd0, 12'd4, 16'd12},
    vec_t'{5'd9,  3'd2, 12'd1, 16'd6},
    vec_t'{5'd11, 3'd7, 12'd8, 16'd16},
    vec_t'{5'd1,  3'd1, 12'd0, 16'd4}
  };
  localparam vec_t V_FIRST = vec_t'{5'd3, 3'd1, 12'd2, 16'd10};
  localparam vec_t V_LATE  = vec_t'{5'd7, 3'd5, 12'd3, 16'd8};
  localparam vec_t V_GAP   = vec_t'{5'd9, 3'd2, 12'd4, 16'd10};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sf_req, sf_user, sf_cs, burst_start;
  logic [4:0]  burst_type;
  logic [2:0]  burst_stream;
  logic [11:0] burst_len;
  logic [15:0] burst_period;
  logic [15:0] pay_word;
  logic        pay_avail, pay_pop;
  logic [31:0] sf_img;
  logic        sf_valid, sf_chan_b, sf_underrun;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] sf_total = 0;
  logic [15:0] src_idx;
  logic [15:0] exp_cnt = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  nonpcm_burst_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .sf_req(sf_req), .sf_user(sf_user), .sf_cs(sf_cs),
    .burst_start(burst_start), .burst_type(burst_type), .burst_stream(burst_stream),
    .burst_len(burst_len), .burst_period(burst_period), .pay_word(pay_word),
    .pay_avail(pay_avail), .pay_pop(pay_pop), .sf_img(sf_img), .sf_valid(sf_valid),
    .sf_chan_b(sf_chan_b), .sf_underrun(sf_underrun)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) src_idx <= 16'h0;
    else if (pay_pop) src_idx <= src_idx + 16'h1;
  end
  assign pay_word = {src_idx[7:0], ~src_idx[7:0]};

  function automatic logic [15:0] pat(input logic [15:0] k);
    return {k[7:0], ~k[7:0]};
  endfunction

  function automatic logic [31:0] exp_img(input logic [15:0] w, input logic u, input logic c);
    logic [31:0] r;
    int ones;
    r = 32'h0;
    for (int i = 0; i < 16; i++) r[12+i] = w[i];
    r[28] = 1'b1;
    r[29] = u;
    r[30] = c;
    ones = 0;
    for (int i = 4; i < 31; i++) ones += int'(r[i]);
    r[31] = (ones % 2) == 1;
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start_req(input vec_t v);
    @(negedge clk);
    burst_start = 1'b1;
    burst_type = v.dt; burst_stream = v.sn; burst_len = v.len; burst_period = v.rep;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic chk_sf(input logic [15:0] ew, input logic eerr, input string tag);
    logic u, c, eb;
    u  = sf_total[1];
    c  = sf_total[0] ^ sf_total[2];
    eb = sf_total[0];
    @(negedge clk);
    sf_req = 1'b1; sf_user = u; sf_cs = c;
    @(negedge clk);
    sf_req = 1'b0;
    chk(sf_img, exp_img(ew, u, c), {tag, " image (R6 R7 R8)"});
    chk({31'h0, sf_chan_b}, {31'h0, eb}, {tag, " R9 channel"});
    chk({31'h0, sf_underrun}, {31'h0, eerr}, {tag, " R10 underrun flag"});
    chk({31'h0, sf_valid}, 32'h1, {tag, " R13 valid"});
    @(negedge clk);
    chk({31'h0, sf_valid}, 32'h0, {tag, " R13 valid single cycle"});
    sf_total = sf_total + 1;
  endtask

  task automatic run_burst(input vec_t v, input int kick_at, input vec_t kv, input int under_at);
    logic [15:0] ew;
    logic        eerr;
    string       tag;
    for (int p = 0; p < int'(v.rep); p++) begin
      if (p == kick_at) start_req(kv);
      eerr = 1'b0;
      if (p == 0)      begin ew = 16'hF872; tag = "R1 sync word A"; end
      else if (p == 1) begin ew = 16'h4E1F; tag = "R1 sync word B"; end
      else if (p == 2) begin ew = {v.sn, 8'h00, v.dt}; tag = "R2 type word"; end
      else if (p == 3) begin ew = {v.len, 4'h0}; tag = "R3 length bits"; end
      else if (p - 4 < int'(v.len)) begin
        if (p == under_at) begin
          pay_avail = 1'b0; ew = 16'h0; eerr = 1'b1; tag = "R10 underrun word";
        end else begin
          ew = pat(exp_cnt); exp_cnt = exp_cnt + 1; tag = "R4 payload";
        end
      end else begin ew = 16'h0; tag = "R5 stuffing"; end
      chk_sf(ew, eerr, tag);
      pay_avail = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sf_req = 1'b0; sf_user = 1'b0; sf_cs = 1'b0; burst_start = 1'b0;
    burst_type = '0; burst_stream = '0; burst_len = '0; burst_period = '0;
    pay_avail = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(sf_img, 32'h0, "R12 reset image");
    chk({31'h0, sf_valid}, 32'h0, "R12 reset valid");
    chk({31'h0, sf_underrun}, 32'h0, "R12 reset underrun");
    chk({31'h0, sf_chan_b}, 32'h0, "R12 reset channel");
    rst_n = 1'b1;

    chk_sf(16'h0, 1'b0, "R12 R5 idle after reset");
    // next subframe is B: the request must wait one subframe (R11)
    start_req(VTAB[0]);
    chk_sf(16'h0, 1'b0, "R11 start waits for channel A");
    run_burst(VTAB[0], -1, VTAB[0], -1);

    for (int i = 1; i < 4; i++) begin
      start_req(VTAB[i]);
      run_burst(VTAB[i], -1, VTAB[i], -1);
    end

    // R11 request during a running burst is held to the period end
    start_req(V_FIRST);
    run_burst(V_FIRST, 5, V_LATE, -1);
    run_burst(V_LATE, -1, V_LATE, -1);

    // R10 missing payload word
    start_req(V_GAP);
    run_burst(V_GAP, -1, V_GAP, 6);

    chk_sf(16'h0, 1'b0, "R5 idle after last burst");

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule